// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an asynchronous 256K x 16 static RAM with a shared data bus. The host raises a one-cycle request with a read/write flag, an 18-bit word address, a two-bit byte mask and 16 bits of write data. The controller then runs one correctly timed memory cycle and answers with a single-cycle ready pulse, carrying read data on reads.

Every memory timing minimum is a nanosecond parameter. At elaboration it becomes a clock-cycle count equal to the ceiling of the nanosecond value over the clock-period parameter. Writes keep output enable high throughout, so the shorter write-pulse minimum applies. After every read the controller waits for the memory's outputs to float before it can start a cycle that drives the data bus. The tri-state data bus is split into an output word, a drive enable and an input word, so the pad ring can build the buffer.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and between cycles: chip select, write enable and output enable are high (inactive), both lane enables are high, the data bus is not driven and ready is low.
- R2: Host mask bit 0 maps to lower lane enable `mem_lane_n[0]` (data bits 7:0) and mask bit 1 maps to `mem_lane_n[1]` (bits 15:8). A set mask bit drives its lane enable low for the cycle, and memory lanes that are not selected keep their contents.
- R3: Output enable stays high for the whole of a write cycle, and write enable is low only while chip select is low.
- R4: A write holds chip select and write enable low for PULSE cycles, where PULSE is the largest cycle count among write pulse (12 ns), data setup (8 ns), address-to-end (12 ns), select-to-end (12 ns) and lane-to-end (12 ns). It then raises both and keeps the data driven for TAIL = max(1, write-cycle count − PULSE) cycles. Ready rises PULSE+TAIL clock edges after the accepting edge.
- R5: A read holds chip select and output enable low with a stable address. It captures data on the edge that comes RD = max(access count, read-cycle count) edges after the accepting edge, and ready rises on that same edge with the captured word.
- R6: After a read the data bus is not driven until at least TURN = cycle count of the 7 ns output-release time has passed since output enable and chip select went high.
- R7: Read data bits in lanes whose mask bit was clear are returned as zero.
- R8: Ready is high for exactly one cycle per request. A request is accepted only from idle, and a request raised while a cycle is in progress is ignored.
- R9: A request with mask 00 gets ready on the accepting edge itself and produces no memory cycle.
- R10: Each cycle count is the ceiling of its nanosecond value over the clock period. A nonzero value gives at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request strobe, sampled in idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_mask | input | 2 | Byte mask, bit 0 = low byte |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with ready |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_drive | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from the memory pins |

## Verification
With a 4 ns clock the defaults give RD = 4, PULSE = 3, TAIL = 1 and TURN = 2. A read's ready is therefore due 4 edges after the accepting edge, a write's ready 4 edges after it, and a zero-mask request's ready on the accepting edge itself. The bench derives these numbers from the nanosecond values with its own ceiling function. It drives requests at falling edges and counts rising edges from the accepting one to the first falling edge at which ready is seen, then compares that count with the expected latency. A model memory on the pins commits each write when write enable rises and serves reads combinationally. A pin monitor measures the write-pulse length, the read-to-drive gap and any overlap of driving, so the content checks and the timing checks sample settled values one half-cycle after each edge.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_TURN,
        ST_WR_PULSE,
        ST_WR_TAIL
    } ctrl_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } bus_ctrl_t;

    localparam bus_ctrl_t BUS_IDLE  = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    localparam bus_ctrl_t BUS_READ  = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
    localparam bus_ctrl_t BUS_WRITE = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
    localparam bus_ctrl_t BUS_HOLD  = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};

    function automatic int ns_to_cycles(input int ns, input int period);
        if (ns <= 0) return 0;
        return (ns + period - 1) / period;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int width_for(input int n);
        int w;
        w = 1;
        while ((1 << w) <= n) w++;
        return w;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata
);
    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (cap_en) begin
                rdata[g*LANE_W +: LANE_W] <= lane_sel[g] ? dq_in[g*LANE_W +: LANE_W]
                                                         : {LANE_W{1'b0}};
            end
        end
    end
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int LANES     = 2,
    parameter int RD_CYC    = 4,
    parameter int TURN_CYC  = 2,
    parameter int PULSE_CYC = 3,
    parameter int TAIL_CYC  = 1,
    parameter int CNT_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              cap_en,
    output logic [LANES-1:0]  cap_lanes,
    output logic              ready,
    output logic [ADDR_W-1:0] mem_addr,
    output bus_ctrl_t         ctrl,
    output logic [LANES-1:0]  lane_n,
    output logic [DATA_W-1:0] dq_out
);
    localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LD  = CNT_W'(TAIL_CYC - 1);

    ctrl_state_e      state, state_nxt;
    bus_ctrl_t        ctrl_nxt;
    logic [LANES-1:0] lane_nxt;
    logic             ready_nxt;
    logic             accept;

    always_comb begin
        state_nxt = state;
        ctrl_nxt  = ctrl;
        lane_nxt  = lane_n;
        ready_nxt = 1'b0;
        accept    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cap_en    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (mask == '0) begin
                        ready_nxt = 1'b1;
                    end else begin
                        accept   = 1'b1;
                        lane_nxt = ~mask;
                        tmr_load = 1'b1;
                        if (wr) begin
                            state_nxt = ST_WR_PULSE;
                            tmr_val   = PULSE_LD;
                            ctrl_nxt  = BUS_WRITE;
                        end else begin
                            state_nxt = ST_RD_ACC;
                            tmr_val   = RD_LD;
                            ctrl_nxt  = BUS_READ;
                        end
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) begin
                    cap_en    = 1'b1;
                    ready_nxt = 1'b1;
                    state_nxt = ST_RD_TURN;
                    tmr_load  = 1'b1;
                    tmr_val   = TURN_LD;
                    ctrl_nxt  = BUS_IDLE;
                    lane_nxt  = '1;
                end
            end
            ST_RD_TURN: begin
                if (tmr_expired) state_nxt = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_nxt = ST_WR_TAIL;
                    tmr_load  = 1'b1;
                    tmr_val   = TAIL_LD;
                    ctrl_nxt  = BUS_HOLD;
                end
            end
            ST_WR_TAIL: begin
                if (tmr_expired) begin
                    state_nxt = ST_IDLE;
                    ready_nxt = 1'b1;
                    ctrl_nxt  = BUS_IDLE;
                    lane_nxt  = '1;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                ctrl_nxt  = BUS_IDLE;
                lane_nxt  = '1;
            end
        endcase
    end

    assign cap_lanes = ~lane_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ctrl     <= BUS_IDLE;
            lane_n   <= '1;
            ready    <= 1'b0;
            mem_addr <= '0;
            dq_out   <= '0;
        end else begin
            state  <= state_nxt;
            ctrl   <= ctrl_nxt;
            lane_n <= lane_nxt;
            ready  <= ready_nxt;
            if (accept) begin
                mem_addr <= addr;
                dq_out   <= wdata;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int LANES     = 2,
    parameter int CLK_NS    = 4,
    parameter int T_AA_NS   = 15,
    parameter int T_RC_NS   = 15,
    parameter int T_OHZ_NS  = 7,
    parameter int T_WP_NS   = 12,
    parameter int T_DW_NS   = 8,
    parameter int T_AW_NS   = 12,
    parameter int T_CW_NS   = 12,
    parameter int T_BW_NS   = 12,
    parameter int T_WC_NS   = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [LANES-1:0]  host_mask,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_lane_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_CYC    = max_of(1, max_of(ns_to_cycles(T_AA_NS, CLK_NS),
                                                ns_to_cycles(T_RC_NS, CLK_NS)));
    localparam int TURN_CYC  = max_of(1, ns_to_cycles(T_OHZ_NS, CLK_NS));
    localparam int PULSE_CYC = max_of(1,
                               max_of(ns_to_cycles(T_WP_NS, CLK_NS),
                               max_of(ns_to_cycles(T_DW_NS, CLK_NS),
                               max_of(ns_to_cycles(T_AW_NS, CLK_NS),
                               max_of(ns_to_cycles(T_CW_NS, CLK_NS),
                                      ns_to_cycles(T_BW_NS, CLK_NS))))));
    localparam int TAIL_CYC  = max_of(1, ns_to_cycles(T_WC_NS, CLK_NS) - PULSE_CYC);
    localparam int CNT_W     = width_for(max_of(max_of(RD_CYC, TURN_CYC),
                                                max_of(PULSE_CYC, TAIL_CYC)));

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cap_en;
    logic [LANES-1:0] cap_lanes;
    bus_ctrl_t        ctrl;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctrl_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .LANES     (LANES),
        .RD_CYC    (RD_CYC),
        .TURN_CYC  (TURN_CYC),
        .PULSE_CYC (PULSE_CYC),
        .TAIL_CYC  (TAIL_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (host_req),
        .wr          (host_wr),
        .addr        (host_addr),
        .mask        (host_mask),
        .wdata       (host_wdata),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .cap_en      (cap_en),
        .cap_lanes   (cap_lanes),
        .ready       (host_ready),
        .mem_addr    (mem_addr),
        .ctrl        (ctrl),
        .lane_n      (mem_lane_n),
        .dq_out      (mem_dq_out)
    );

    sram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .lane_sel (cap_lanes),
        .dq_in    (mem_dq_in),
        .rdata    (host_rdata)
    );

    assign mem_ce_n     = ctrl.ce_n;
    assign mem_we_n     = ctrl.we_n;
    assign mem_oe_n     = ctrl.oe_n;
    assign mem_dq_drive = ctrl.drive;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W    = 18,
    parameter int TURN_CYC  = 2,
    parameter int PULSE_CYC = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              host_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_drive
);
    localparam logic [7:0] TURN_MIN  = 8'(TURN_CYC);
    localparam logic [7:0] PULSE_MIN = 8'(PULSE_CYC);

    logic [7:0] rel_cnt;
    logic [7:0] wlow_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_cnt  <= 8'hFF;
            wlow_cnt <= '0;
        end else begin
            if (!mem_ce_n && !mem_oe_n) rel_cnt <= '0;
            else if (rel_cnt != 8'hFF)  rel_cnt <= rel_cnt + 1'b1;
            if (!mem_we_n) begin
                if (wlow_cnt != 8'hFF) wlow_cnt <= wlow_cnt + 1'b1;
            end else begin
                wlow_cnt <= '0;
            end
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_drive && !host_ready));

    p_we_inside_cs_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n);

    p_oe_off_in_write_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    p_pulse_length_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_we_n && !$past(mem_we_n)) |-> (wlow_cnt >= PULSE_MIN));

    p_read_addr_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    p_no_drive_while_read_r6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_drive |-> mem_oe_n);

    p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_drive) |-> (rel_cnt >= TURN_MIN));

    p_ready_single_r8: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);
endmodule

bind sram_async_ctrl sram_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .TURN_CYC  (TURN_CYC),
    .PULSE_CYC (PULSE_CYC)
) u_chk (.*);

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [17:0] host_addr = '0;
    logic [1:0]  host_mask = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ready;
    logic [15:0] host_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_drive;
    logic [15:0] mem_dq_in;

    always #2 clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (.*);

    function automatic int cyc(input int ns);
        return (ns == 0) ? 0 : (ns + 3) / 4;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    int exp_rd, exp_pulse, exp_tail, exp_turn;
    int checks = 0, fails = 0;

    logic [15:0] model [0:255];
    wire mem_drives = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_in = mem_drives ?
        {mem_lane_n[1] ? 8'hzz : model[mem_addr[7:0]][15:8],
         mem_lane_n[0] ? 8'hzz : model[mem_addr[7:0]][7:0]} : 16'hzzzz;

    int ce_falls = 0, readies = 0, ready_long = 0, oe_viol = 0, contention = 0;
    int wlen_cur = 0, wlen_last = 0, gap = 255, last_gap = 255, drive_err = 0;
    logic prev_we_n = 1'b1, prev_ce_n = 1'b1, prev_ready = 1'b0, prev_drive = 1'b0;
    logic [1:0]  prev_lane = 2'b11;
    logic [15:0] prev_data = '0;
    logic [17:0] prev_addr = '0;

    always @(posedge clk) begin
        if (!rst) begin
            if (!prev_we_n && mem_we_n) begin
                wlen_last = wlen_cur;
                if (!prev_drive) drive_err++;
                if (!prev_lane[0]) model[prev_addr[7:0]][7:0]  = prev_data[7:0];
                if (!prev_lane[1]) model[prev_addr[7:0]][15:8] = prev_data[15:8];
            end
            wlen_cur = mem_we_n ? 0 : wlen_cur + 1;
            if (prev_ce_n && !mem_ce_n) ce_falls++;
            if (host_ready) readies++;
            if (host_ready && prev_ready) ready_long++;
            if (!mem_we_n && !mem_oe_n) oe_viol++;
            if (mem_dq_drive && mem_drives) contention++;
            if (mem_dq_drive && !prev_drive) last_gap = gap;
            if (mem_drives) gap = 0; else if (gap < 255) gap++;
        end
        prev_we_n = mem_we_n; prev_ce_n = mem_ce_n; prev_ready = host_ready;
        prev_drive = mem_dq_drive; prev_lane = mem_lane_n;
        prev_data = mem_dq_out; prev_addr = mem_addr;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic wr, input logic [17:0] a, input logic [1:0] m,
                         input logic [15:0] wd, output int lat, output logic [15:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_mask = m; host_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        lat = 0;
        while (!host_ready && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        rd = host_rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && mem_lane_n == 2'b11 && !mem_dq_drive
              && !host_ready, "R1 reset idle",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_drive, host_ready}, 7'b1111100);
    endtask

    task automatic t_zero_mask();
        int lat; logic [15:0] rd; int c0;
        c0 = ce_falls;
        do_op(1'b1, 18'h00010, 2'b00, 16'hFFFF, lat, rd);
        check(lat == 0, "R9 zero-mask latency", lat, 0);
        settle();
        check(ce_falls == c0 && model[8'h10] == (16'hA5A5 ^ 16'h10), "R9 no memory cycle",
              ce_falls - c0, 0);
    endtask

    task automatic t_write_full();
        int lat; logic [15:0] rd;
        do_op(1'b1, 18'h00020, 2'b11, 16'h1234, lat, rd);
        check(lat == exp_pulse + exp_tail, "R4 R10 write latency", lat, exp_pulse + exp_tail);
        settle();
        check(model[8'h20] == 16'h1234, "R4 write data", model[8'h20], 16'h1234);
        check(wlen_last == exp_pulse && drive_err == 0, "R4 pulse length", wlen_last, exp_pulse);
        check(oe_viol == 0, "R3 oe high during write", oe_viol, 0);
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_drive && mem_lane_n == 2'b11,
              "R1 back to idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive}, 4'b1110);
    endtask

    task automatic t_write_lanes();
        int lat; logic [15:0] rd;
        do_op(1'b1, 18'h00030, 2'b01, 16'hBEEF, lat, rd);
        settle();
        check(model[8'h30] == {8'hA5 ^ 8'h00, 8'hEF}, "R2 lower lane only",
              model[8'h30], {8'hA5, 8'hEF});
        do_op(1'b1, 18'h00031, 2'b10, 16'hC0DE, lat, rd);
        settle();
        check(model[8'h31] == {8'hC0, 8'hA5 ^ 8'h31}, "R2 upper lane only",
              model[8'h31], {8'hC0, 8'hA5 ^ 8'h31});
    endtask

    task automatic t_read();
        int lat; logic [15:0] rd;
        do_op(1'b0, 18'h00020, 2'b11, 16'h0, lat, rd);
        check(lat == exp_rd, "R5 R10 read latency", lat, exp_rd);
        check(rd == 16'h1234, "R5 read data", rd, 16'h1234);
        settle();
        do_op(1'b0, 18'h00040, 2'b01, 16'h0, lat, rd);
        check(rd == {8'h00, 8'hA5 ^ 8'h40}, "R7 lower-only read", rd, {8'h00, 8'hA5 ^ 8'h40});
        settle();
        do_op(1'b0, 18'h00041, 2'b10, 16'h0, lat, rd);
        check(rd == {8'hA5, 8'h00}, "R7 upper-only read", rd, {8'hA5, 8'h00});
        settle();
    endtask

    task automatic t_turnaround();
        int lat; logic [15:0] rd; int n;
        do_op(1'b0, 18'h00020, 2'b11, 16'h0, lat, rd);
        host_req = 1'b1; host_wr = 1'b1; host_addr = 18'h00050;
        host_mask = 2'b11; host_wdata = 16'h5A5A;
        n = 0;
        while (mem_ce_n && n < 50) begin
            @(negedge clk);
            n++;
        end
        host_req = 1'b0;
        while (!host_ready && n < 100) begin
            @(negedge clk);
            n++;
        end
        settle();
        check(last_gap >= exp_turn, "R6 release gap before drive", last_gap, exp_turn);
        check(contention == 0, "R6 no bus contention", contention, 0);
        check(model[8'h50] == 16'h5A5A, "R6 write after read", model[8'h50], 16'h5A5A);
    endtask

    task automatic t_busy_ignore();
        int c0, r0; int n;
        c0 = ce_falls; r0 = readies;
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_addr = 18'h00060;
        host_mask = 2'b11; host_wdata = 16'h6161;
        @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
        host_req = 1'b1; host_addr = 18'h00061; host_wdata = 16'h7777;
        @(negedge clk);
        host_req = 1'b0;
        n = 0;
        while (!host_ready && n < 50) begin
            @(negedge clk);
            n++;
        end
        settle();
        check(ce_falls - c0 == 1 && readies - r0 == 1, "R8 busy request ignored",
              (ce_falls - c0) * 16 + (readies - r0), 17);
        check(model[8'h61] == (16'hA5A5 ^ 16'h61), "R8 ignored address untouched",
              model[8'h61], 16'hA5A5 ^ 16'h61);
        check(ready_long == 0, "R8 ready single cycle", ready_long, 0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        exp_rd    = mx(1, mx(cyc(15), cyc(15)));
        exp_pulse = mx(cyc(12), mx(cyc(8), cyc(12)));
        exp_tail  = mx(1, cyc(15) - exp_pulse);
        exp_turn  = mx(1, cyc(7));
        for (int i = 0; i < 256; i++) model[i] = 16'hA5A5 ^ 16'(i);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_zero_mask();
        t_write_full();
        t_write_lanes();
        t_read();
        t_turnaround();
        t_busy_ignore();
        report();
    end
endmodule